// File: doc/BRIEF.md
# Fuse-Link Programmable Logic Array

This block is a soft model of a programmable AND-OR logic array with `N_IN` inputs, `N_TERM` product terms and `N_OUT` outputs. Every programmable connection is held as one link bit. A set bit means the link is intact and a clear bit means it is blown. Each product term can connect to each input in true form and to each input in complemented form. Each product term can also connect to each output's sum gate. Each output ends in an XOR stage. The second input of that XOR links to logic 0 through one link and to logic 1 through another, so the output can be the sum itself or its inverse. The link store holds exactly 2·N_IN·N_TERM + N_TERM·N_OUT + 2·N_OUT bits.

The link map is loaded through a synchronous write port, one entry per strobe. Reset leaves every link intact, which is the state of an unprogrammed part. The outputs are computed combinationally from the live inputs and the current link map. A sum-of-products design is loaded by writing one row per product term and one polarity entry per output.

Top module: `pla_fuse_array`

## Requirements
- R1: After reset every link is intact. Every product term is then 0, every sum is 0, and every output reads 1 for any input value.
- R2: A product term row holds 2·N_IN AND links. Bit 2i links input i in true form, and the term needs that input to be 1. Bit 2i+1 links input i in complemented form, and the term needs that input to be 0. A blown link counts as 1, so a term with every AND link blown is always 1.
- R3: A product term with every AND link intact is always 0.
- R4: The sum for output j is the OR of the product terms whose OR link to output j is intact. If no term is linked to output j, that sum is 0.
- R5: If the polarity link to logic 1 of output j is intact, the output is the inverse of its sum. Otherwise the output equals its sum. When both polarity links are intact, the XOR input resolves to 1.
- R6: A write to an address t below N_TERM loads row t. cfg_data bits [2·N_IN-1:0] go to the AND links, and bit 2·N_IN+j goes to the OR link to output j. The new links take effect from the clock edge that captures the write. Outputs follow in_i with no clock delay.
- R7: A write to address N_TERM+j loads the polarity links of output j. cfg_data bit 0 is the link to logic 0 and bit 1 is the link to logic 1. All other data bits are ignored.
- R8: A write to an address of N_TERM+N_OUT or above changes no link.
- R9: While cfg_we is low, no link changes, whatever is on cfg_addr and cfg_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the link store |
| rst_n | input | 1 | Active-low asynchronous reset; sets every link intact |
| cfg_we | input | 1 | Write strobe for the link map |
| cfg_addr | input | $clog2(N_TERM+N_OUT) | Row number, or N_TERM plus an output index |
| cfg_data | input | 2·N_IN+N_OUT | Link bits for the selected entry (1 = intact) |
| in_i | input | N_IN | Live logic inputs |
| out_o | output | N_OUT | Evaluated outputs |

## Verification
The main function is tested with the three-input majority design. AB, AC, BC and A'B'C' are shared between a complemented output and a true output, and all eight input codes are applied. This shows that a single term can feed several sums and that the two polarities give different results. Degenerate rows are also applied. A row with every link blown separates "open counts as 1" from "open counts as 0". A row with every link intact separates the self-cancelling term from a don't-care. An output with no OR links shows that an empty sum is 0 before polarity. Polarity entries with both links blown and with stray upper data bits check how the XOR tie resolves. Out-of-range and unstrobed writes are applied over a known map, and all eight input codes are compared again afterwards.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    TGT_ROW  = 2'd0,
    TGT_POL  = 2'd1,
    TGT_NONE = 2'd2
  } cfg_tgt_e;

  // Number of programmable links for an array of the given size.
  function automatic int unsigned pla_link_count(input int unsigned n_in,
                                                 input int unsigned n_term,
                                                 input int unsigned n_out);
    return 2 * n_in * n_term + n_term * n_out + 2 * n_out;
  endfunction

  // Classify a configuration address.
  function automatic cfg_tgt_e pla_decode(input int unsigned addr,
                                          input int unsigned n_term,
                                          input int unsigned n_out);
    if (addr < n_term)              return TGT_ROW;
    else if (addr < n_term + n_out) return TGT_POL;
    else                            return TGT_NONE;
  endfunction

endpackage

// File: rtl/pla_link_store.sv
module pla_link_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = 3,
  parameter int DW     = 2 * N_IN + N_OUT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [DW-1:0]              cfg_data,
  output logic [2*N_IN*N_TERM-1:0]   and_lk,
  output logic [N_TERM*N_OUT-1:0]    or_lk,
  output logic [2*N_OUT-1:0]         pol_lk,
  output logic [N_TERM-1:0]          row_wr,
  output logic [N_OUT-1:0]           pol_wr
);

  localparam int ROW_W     = 2 * N_IN;
  localparam int AND_BITS  = ROW_W * N_TERM;
  localparam int OR_BITS   = N_TERM * N_OUT;
  localparam int LINK_BITS = int'(pla_link_count(N_IN, N_TERM, N_OUT));
  localparam int OR_BASE   = AND_BITS;
  localparam int POL_BASE  = AND_BITS + OR_BITS;

  logic [LINK_BITS-1:0] fuse_q;
  cfg_tgt_e             tgt;

  // Address decode into one-hot write events.
  always_comb begin
    tgt    = pla_decode(int'(cfg_addr), N_TERM, N_OUT);
    row_wr = '0;
    pol_wr = '0;
    if (cfg_we) begin
      for (int t = 0; t < N_TERM; t++)
        if (tgt == TGT_ROW && int'(cfg_addr) == t) row_wr[t] = 1'b1;
      for (int j = 0; j < N_OUT; j++)
        if (tgt == TGT_POL && int'(cfg_addr) == N_TERM + j) pol_wr[j] = 1'b1;
    end
  end

  // Unprogrammed part: every link intact.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_q <= '1;
    end else begin
      for (int t = 0; t < N_TERM; t++) begin
        if (row_wr[t]) begin
          fuse_q[t*ROW_W +: ROW_W]         <= cfg_data[ROW_W-1:0];
          fuse_q[OR_BASE + t*N_OUT +: N_OUT] <= cfg_data[ROW_W +: N_OUT];
        end
      end
      for (int j = 0; j < N_OUT; j++) begin
        if (pol_wr[j]) fuse_q[POL_BASE + 2*j +: 2] <= cfg_data[1:0];
      end
    end
  end

  assign and_lk = fuse_q[AND_BITS-1:0];
  assign or_lk  = fuse_q[OR_BASE +: OR_BITS];
  assign pol_lk = fuse_q[POL_BASE +: 2*N_OUT];

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4
) (
  input  logic [N_IN-1:0]            in_i,
  input  logic [2*N_IN*N_TERM-1:0]   and_lk,
  output logic [N_TERM-1:0]          term_hit
);

  localparam int ROW_W = 2 * N_IN;

  // An intact link passes its literal; a blown link behaves as a 1.
  function automatic logic eval_term(input logic [ROW_W-1:0] lk,
                                     input logic [N_IN-1:0]  x);
    logic p;
    p = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (lk[2*i]   && !x[i]) p = 1'b0;
      if (lk[2*i+1] &&  x[i]) p = 1'b0;
    end
    return p;
  endfunction

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign term_hit[t] = eval_term(and_lk[t*ROW_W +: ROW_W], in_i);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]         term_hit,
  input  logic [N_TERM*N_OUT-1:0]   or_lk,
  input  logic [2*N_OUT-1:0]        pol_lk,
  output logic [N_OUT-1:0]          sum_raw,
  output logic [N_OUT-1:0]          pol_inv,
  output logic [N_OUT-1:0]          out_o
);

  // Sum of the terms whose link to output j is intact.
  function automatic logic eval_sum(input logic [N_TERM-1:0]       hit,
                                    input logic [N_TERM*N_OUT-1:0] lk,
                                    input int                      j);
    logic s;
    s = 1'b0;
    for (int t = 0; t < N_TERM; t++)
      if (lk[t*N_OUT + j]) s = s | hit[t];
    return s;
  endfunction

  // XOR tie input: wired-OR of the link to 0 and the link to 1.
  function automatic logic tie_value(input logic [1:0] lk);
    return (lk[0] & 1'b0) | (lk[1] & 1'b1);
  endfunction

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign sum_raw[j] = eval_sum(term_hit, or_lk, j);
    assign pol_inv[j] = tie_value(pol_lk[2*j +: 2]);
    assign out_o[j]   = sum_raw[j] ^ pol_inv[j];
  end

endmodule

// File: rtl/pla_fuse_array.sv
module pla_fuse_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = ($clog2(N_TERM + N_OUT) < 1) ? 1 : $clog2(N_TERM + N_OUT),
  parameter int DW     = 2 * N_IN + N_OUT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_data,
  input  logic [N_IN-1:0] in_i,
  output logic [N_OUT-1:0] out_o
);

  logic [2*N_IN*N_TERM-1:0] and_lk;
  logic [N_TERM*N_OUT-1:0]  or_lk;
  logic [2*N_OUT-1:0]       pol_lk;
  logic [N_TERM-1:0]        row_wr;
  logic [N_OUT-1:0]         pol_wr;
  logic [N_TERM-1:0]        term_hit;
  logic [N_OUT-1:0]         sum_raw;
  logic [N_OUT-1:0]         pol_inv;

  pla_link_store #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW), .DW(DW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .and_lk(and_lk), .or_lk(or_lk), .pol_lk(pol_lk),
    .row_wr(row_wr), .pol_wr(pol_wr)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_i(in_i), .and_lk(and_lk), .term_hit(term_hit)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_hit(term_hit), .or_lk(or_lk), .pol_lk(pol_lk),
    .sum_raw(sum_raw), .pol_inv(pol_inv), .out_o(out_o)
  );

endmodule

// File: rtl/pla_fuse_array_chk.sv
module pla_fuse_array_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = 3,
  parameter int DW     = 2 * N_IN + N_OUT
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [AW-1:0]            cfg_addr,
  input logic [DW-1:0]            cfg_data,
  input logic [N_OUT-1:0]         out_o,
  input logic [2*N_IN*N_TERM-1:0] and_lk,
  input logic [N_TERM*N_OUT-1:0]  or_lk,
  input logic [2*N_OUT-1:0]       pol_lk,
  input logic [N_TERM-1:0]        term_hit,
  input logic [N_OUT-1:0]         sum_raw
);

  localparam int ROW_W = 2 * N_IN;

  logic wrote;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wrote <= 1'b0;
    else if (cfg_we) wrote <= 1'b1;
  end

  assert_unprogrammed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrote |-> (&and_lk && &or_lk && &pol_lk));

  assert_bad_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_addr) >= N_TERM + N_OUT)
      |=> ($stable(and_lk) && $stable(or_lk) && $stable(pol_lk)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(and_lk) && $stable(or_lk) && $stable(pol_lk)));

  for (genvar t = 0; t < N_TERM; t++) begin : g_t
    assert_open_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (and_lk[t*ROW_W +: ROW_W] == '0) |-> term_hit[t]);

    assert_intact_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (&and_lk[t*ROW_W +: ROW_W]) |-> !term_hit[t]);

    assert_row_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_addr) == t)
        |=> (and_lk[t*ROW_W +: ROW_W] == $past(cfg_data[ROW_W-1:0]) &&
             or_lk[t*N_OUT +: N_OUT]  == $past(cfg_data[ROW_W +: N_OUT])));
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_j
    logic [N_TERM-1:0] col;
    for (genvar t = 0; t < N_TERM; t++) begin : g_c
      assign col[t] = or_lk[t*N_OUT + j];
    end

    assert_empty_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (col == '0) |-> !sum_raw[j]);

    assert_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pol_lk[2*j+1] ? (out_o[j] != sum_raw[j]) : (out_o[j] == sum_raw[j]));

    assert_pol_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_addr) == N_TERM + j)
        |=> (pol_lk[2*j +: 2] == $past(cfg_data[1:0])));
  end

endmodule

bind pla_fuse_array pla_fuse_array_chk #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_data(cfg_data), .out_o(out_o), .and_lk(and_lk), .or_lk(or_lk),
  .pol_lk(pol_lk), .term_hit(term_hit), .sum_raw(sum_raw)
);

// File: tb/pla_fuse_array_bench.sv
module pla_fuse_array_bench;

  localparam int N_IN   = 3;
  localparam int N_TERM = 4;
  localparam int N_OUT  = 2;
  localparam int AW     = 3;
  localparam int DW     = 2 * N_IN + N_OUT;
  localparam int DASH   = 2;

  // {C,B,A input code, expected {F2,F1}} for the majority design
  localparam logic [4:0] VEC [8] = '{
    {3'd0, 2'b11}, {3'd1, 2'b01}, {3'd2, 2'b01}, {3'd3, 2'b10},
    {3'd4, 2'b01}, {3'd5, 2'b10}, {3'd6, 2'b00}, {3'd7, 2'b10}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [AW-1:0]   cfg_addr = '0;
  logic [DW-1:0]   cfg_data = '0;
  logic [N_IN-1:0] in_i = '0;
  logic [N_OUT-1:0] out_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [2*N_IN-1:0] sh_and [N_TERM];
  logic [N_OUT-1:0]  sh_or  [N_TERM];
  logic [1:0]        sh_pol [N_OUT];

  always #10 clk = ~clk;

  pla_fuse_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_pla_fuse_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_i(in_i), .out_o(out_o)
  );

  // Row codes per input: 1 true, 0 complement, DASH no connection.
  function automatic logic [DW-1:0] mk_row(input int ca, input int cb, input int cc,
                                           input logic [N_OUT-1:0] orl);
    logic [DW-1:0] r;
    int c [3];
    c[0] = ca; c[1] = cb; c[2] = cc;
    r = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (c[i] == 1) r[2*i]   = 1'b1;
      if (c[i] == 0) r[2*i+1] = 1'b1;
    end
    r[2*N_IN +: N_OUT] = orl;
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] ref_out(input logic [N_IN-1:0] x);
    logic [N_OUT-1:0] o;
    for (int j = 0; j < N_OUT; j++) begin
      logic s;
      s = 1'b0;
      for (int t = 0; t < N_TERM; t++) begin
        logic p;
        p = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
          if (sh_and[t][2*i] == 1'b1 && x[i] == 1'b0) p = 1'b0;
          if (sh_and[t][2*i+1] == 1'b1 && x[i] == 1'b1) p = 1'b0;
        end
        if (sh_or[t][j]) s = s | p;
      end
      o[j] = sh_pol[j][1] ? ~s : s;
    end
    return o;
  endfunction

  task automatic shadow_reset();
    for (int t = 0; t < N_TERM; t++) begin sh_and[t] = '1; sh_or[t] = '1; end
    for (int j = 0; j < N_OUT; j++) sh_pol[j] = 2'b11;
  endtask

  task automatic cfg_write(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < N_TERM) begin
      sh_and[addr] = data[2*N_IN-1:0];
      sh_or[addr]  = data[2*N_IN +: N_OUT];
    end else if (addr < N_TERM + N_OUT) begin
      sh_pol[addr-N_TERM] = data[1:0];
    end
  endtask

  task automatic check(input string req, input logic [N_OUT-1:0] act,
                       input logic [N_OUT-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, in_i, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int v = 0; v < 8; v++) begin
      in_i = N_IN'(v);
      #2;
      check(req, out_o, ref_out(in_i));
    end
  endtask

  task automatic load_majority();
    cfg_write(0, mk_row(1, 1, DASH, 2'b11));     // AB
    cfg_write(1, mk_row(1, DASH, 1, 2'b11));     // AC
    cfg_write(2, mk_row(DASH, 1, 1, 2'b01));     // BC
    cfg_write(3, mk_row(0, 0, 0, 2'b10));        // A'B'C'
    cfg_write(N_TERM + 0, DW'(2'b10));           // F1: complemented
    cfg_write(N_TERM + 1, DW'(2'b01));           // F2: true
  endtask

  initial begin
    shadow_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: unprogrammed array drives all ones
    for (int v = 0; v < 8; v++) begin
      in_i = N_IN'(v);
      #2;
      check("R1", out_o, 2'b11);
    end

    // R6: majority design from the vector table, plus R2 via the model
    load_majority();
    for (int k = 0; k < 8; k++) begin
      in_i = VEC[k][4:2];
      #2;
      check("R6", out_o, VEC[k][1:0]);
    end
    check_all("R2");

    // R8: out-of-range writes
    cfg_write(N_TERM + N_OUT, '0);
    cfg_write(7, '0);
    check_all("R8");

    // R9: data presented without the strobe
    @(negedge clk);
    cfg_addr = AW'(0); cfg_data = '0;
    @(negedge clk);
    cfg_addr = AW'(N_TERM); cfg_data = '0;
    @(negedge clk);
    check_all("R9");

    // R7: upper data bits ignored on a polarity write
    cfg_write(N_TERM + 1, {{(DW-2){1'b1}}, 2'b01});
    check_all("R7");
    cfg_write(N_TERM + 0, DW'(2'b01));
    check_all("R5");
    // R5: both polarity links blown gives the true sum
    cfg_write(N_TERM + 0, DW'(2'b00));
    check_all("R5");
    cfg_write(N_TERM + 0, DW'(2'b11));
    check_all("R5");

    // R2: fully blown row is a constant 1 feeding output 0
    load_majority();
    cfg_write(N_TERM + 0, DW'(2'b01));
    cfg_write(0, mk_row(DASH, DASH, DASH, 2'b01));
    for (int v = 0; v < 8; v++) begin
      in_i = N_IN'(v);
      #2;
      check("R2", out_o[0], 1'b1);
    end

    // R3: fully intact row contributes nothing
    cfg_write(0, {2'b11, {(2*N_IN){1'b1}}});
    check_all("R3");

    // R4: output 1 with no OR links is an empty sum
    cfg_write(N_TERM + 1, DW'(2'b01));
    for (int t = 0; t < N_TERM; t++) cfg_write(t, mk_row(DASH, DASH, DASH, 2'b01));
    for (int v = 0; v < 8; v++) begin
      in_i = N_IN'(v);
      #2;
      check("R4", out_o[1], 1'b0);
    end
    cfg_write(N_TERM + 1, DW'(2'b10));
    check_all("R4");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule